// File: doc/BRIEF.md
# Run-time Tapped Serial Delay Line

This block is a bit-serial delay line whose storage is a chain of flip-flops, arranged the way a lookup table is reused as a shifter. On each rising clock edge with the shift enable high, the new input bit enters the first stage and every stored bit moves one stage further along. An address input selects which stage drives the tap output through a combinational selector. Because of this, the delay seen on the tap can be changed from one cycle to the next without touching the stored data.

The last stage always drives a separate cascade output, whatever the address. Several units can therefore be chained, each cascade output feeding the next unit's data input, to make longer delay lines. The lane count is a parameter: each lane is an independent one-bit line, and all lanes share the clock, the enable and the address. This suits balancing wide datapaths, for example 64 lanes each delayed by 17 cycles.

The storage has no reset. Its power-up contents come from a parameter. A second parameter chooses how the tap selector is built: a flat indexed select or a balanced binary tree of 2:1 multiplexers.

Top module: `tap_shift_line`

## Requirements
- R1: With the default depth of 32 there are 32 stages per lane. On a rising clock edge with `shift_en` = 1, `din` is stored in stage 0 and stage k takes the old value of stage k-1.
- R2: On a rising clock edge with `shift_en` = 0, no stage changes, whatever `din` is.
- R3: With `shift_en` held high, `tap_sel` = N (binary stage index 0..31) puts on `tap_out` the `din` value sampled N+1 edges earlier.
- R4: `tap_out` is a combinational function of `tap_sel` and the stored stages. A change of `tap_sel` shows on `tap_out` with no clock edge.
- R5: `cascade_out` always carries stage 31 (the last stage), independent of `tap_sel`. It equals `tap_out` whenever `tap_sel` = 31.
- R6: There is no reset. At power-up every stage of every lane holds the value of parameter `INIT_BIT`.
- R7: Lanes are independent. Bit i of `tap_out` and `cascade_out` depends only on bit i of `din`.
- R8: Two units chained, the first one's `cascade_out` driving the second one's `din` with a common `shift_en`, form a 64-deep line. Tap N of the second unit is position 32+N of the combined line.
- R9: `MUX_TREE` = 1 (tree of 2:1 multiplexers) and `MUX_TREE` = 0 (flat indexed select) give identical `tap_out` for the same stored stages and address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge |
| shift_en | input | 1 | Shift enable, active high |
| din | input | LANES | Serial input bit, one per lane |
| tap_sel | input | ADDR_W (5) | Stage index driving the tap output |
| tap_out | output | LANES | Selected stage, per lane |
| cascade_out | output | LANES | Last stage, per lane, for chaining |

## Verification
An impulse test sends a single one through a line of zeros. It moves the tap along with the impulse and checks the neighbouring address, which separates an off-by-one delay from a correct N+1 delay. A hold test sweeps every address before and after edges with the enable low while `din` toggles, so any stray shift or a lost enable shows up. A long random run uses random enables, per-lane data and independent addresses on a chained pair, one tree and one flat selector, and compares both against a 64-entry queue. That separates crossed lanes, a wrong cascade stage and selector variants that disagree. A sweep of addresses between clock edges confirms that the tap follows the address with no edge.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

   localparam int unsigned TSL_DEF_DEPTH = 32;
   localparam int unsigned TSL_DEF_LANES = 2;

   // Address width needed to index a line of the given depth.
   function automatic int unsigned tsl_addr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   // True when the depth is a power of two (needed by the tree selector).
   function automatic bit tsl_is_pow2(input int unsigned depth);
      return (depth != 0) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/tsl_lane_store.sv
module tsl_lane_store #(
   parameter int unsigned DEPTH    = tsl_pkg::TSL_DEF_DEPTH,
   parameter bit          INIT_BIT = 1'b0
) (
   input  logic             clk,
   input  logic             shift_en,
   input  logic             din,
   output logic [DEPTH-1:0] stages
);

   // Power-up value only; the storage has no reset.
   logic [DEPTH-1:0] store_q = {DEPTH{INIT_BIT}};

   always_ff @(posedge clk) begin
      if (shift_en) begin
         store_q <= {store_q[DEPTH-2:0], din};
      end
   end

   assign stages = store_q;

endmodule

// File: rtl/tsl_tap_mux.sv
module tsl_tap_mux #(
   parameter int unsigned DEPTH    = tsl_pkg::TSL_DEF_DEPTH,
   parameter int unsigned ADDR_W   = tsl_pkg::tsl_addr_bits(DEPTH),
   parameter bit          MUX_TREE = 1'b1
) (
   input  logic [DEPTH-1:0]  stages,
   input  logic [ADDR_W-1:0] sel,
   output logic              tap
);

   if (MUX_TREE) begin : g_tree
      // Level lv holds 2**lv nodes; level ADDR_W is the leaves.
      // Node j of level lv picks child 2j or 2j+1 by address bit ADDR_W-1-lv.
      for (genvar lv = ADDR_W; lv >= 0; lv--) begin : g_lvl
         logic [(1 << lv)-1:0] v;
         if (lv == ADDR_W) begin : g_leaf
            assign v = stages;
         end else begin : g_node
            for (genvar j = 0; j < (1 << lv); j++) begin : g_pick
               assign v[j] = sel[ADDR_W-1-lv] ? g_lvl[lv+1].v[2*j+1]
                                              : g_lvl[lv+1].v[2*j];
            end
         end
      end
      assign tap = g_lvl[0].v[0];
   end else begin : g_flat
      assign tap = stages[sel];
   end

endmodule

// File: rtl/tap_shift_line.sv
module tap_shift_line #(
   parameter int unsigned LANES    = tsl_pkg::TSL_DEF_LANES,
   parameter int unsigned DEPTH    = tsl_pkg::TSL_DEF_DEPTH,
   parameter bit          INIT_BIT = 1'b0,
   parameter bit          MUX_TREE = 1'b1,
   localparam int unsigned ADDR_W  = tsl_pkg::tsl_addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              shift_en,
   input  logic [LANES-1:0]  din,
   input  logic [ADDR_W-1:0] tap_sel,
   output logic [LANES-1:0]  tap_out,
   output logic [LANES-1:0]  cascade_out
);

   localparam int unsigned LAST = DEPTH - 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("tap_shift_line: LANES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("tap_shift_line: DEPTH must be at least 2");
   end
   if (!tsl_pkg::tsl_is_pow2(DEPTH)) begin : g_bad_pow2
      $error("tap_shift_line: DEPTH must be a power of two");
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [DEPTH-1:0] stages;

      tsl_lane_store #(
         .DEPTH    (DEPTH),
         .INIT_BIT (INIT_BIT)
      ) u_store (
         .clk      (clk),
         .shift_en (shift_en),
         .din      (din[ln]),
         .stages   (stages)
      );

      tsl_tap_mux #(
         .DEPTH    (DEPTH),
         .ADDR_W   (ADDR_W),
         .MUX_TREE (MUX_TREE)
      ) u_mux (
         .stages   (stages),
         .sel      (tap_sel),
         .tap      (tap_out[ln])
      );

      assign cascade_out[ln] = stages[LAST];
   end

endmodule

// File: rtl/tap_shift_line_chk.sv
module tap_shift_line_chk #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              shift_en,
   input logic [LANES-1:0]  din,
   input logic [ADDR_W-1:0] tap_sel,
   input logic [LANES-1:0]  tap_out,
   input logic [LANES-1:0]  cascade_out
);

   localparam logic [ADDR_W-1:0] LAST_SEL = ADDR_W'(DEPTH - 1);

   // No reset exists: properties are held off until one edge has passed.
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R1: an enabled edge puts din in stage 0
   p_load_r1: assert property (@(posedge clk) disable iff (!armed)
      shift_en |=> (tap_sel != '0 || tap_out == $past(din)));

   // R2: with the enable low the last stage does not move
   p_hold_casc_r2: assert property (@(posedge clk) disable iff (!armed)
      !shift_en |=> $stable(cascade_out));

   // R2: with the enable low and the same address the tap does not move
   p_hold_tap_r2: assert property (@(posedge clk) disable iff (!armed)
      !shift_en |=> (tap_sel != $past(tap_sel) || tap_out == $past(tap_out)));

   // R3: one enabled edge moves a bit exactly one stage further
   p_step_r3: assert property (@(posedge clk) disable iff (!armed)
      (shift_en && tap_sel != LAST_SEL) |=>
         (tap_sel != ($past(tap_sel) + ADDR_W'(1)) || tap_out == $past(tap_out)));

   // R5: the cascade output is the last stage
   p_casc_r5: assert property (@(posedge clk) disable iff (!armed)
      (tap_sel == LAST_SEL) |-> (tap_out == cascade_out));

endmodule

bind tap_shift_line tap_shift_line_chk #(
   .LANES  (LANES),
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk         (clk),
   .shift_en    (shift_en),
   .din         (din),
   .tap_sel     (tap_sel),
   .tap_out     (tap_out),
   .cascade_out (cascade_out)
);

// File: tb/tap_shift_line_tb.sv
module tap_shift_line_tb;

   localparam int CLK_PERIOD = 10;
   localparam int L          = 4;
   localparam int D          = 32;
   localparam int AW         = 5;
   localparam bit INIT       = 1'b1;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          shift_en;
   logic [L-1:0]  din;
   logic [AW-1:0] sel1, sel2;
   logic [L-1:0]  tap1, casc1, tap2, casc2;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // Reference: combined 64-deep line, index 0 is the newest bit.
   logic [L-1:0] line_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tap_shift_line #(.LANES(L), .DEPTH(D), .INIT_BIT(INIT), .MUX_TREE(1'b1)) u_dut (
      .clk(clk), .shift_en(shift_en), .din(din), .tap_sel(sel1),
      .tap_out(tap1), .cascade_out(casc1));

   tap_shift_line #(.LANES(L), .DEPTH(D), .INIT_BIT(INIT), .MUX_TREE(1'b0)) u_dut2 (
      .clk(clk), .shift_en(shift_en), .din(casc1), .tap_sel(sel2),
      .tap_out(tap2), .cascade_out(casc2));

   initial begin
      for (int i = 0; i < 2*D; i++) line_q.push_back({L{INIT}});
   end

   always @(posedge clk) begin
      if (shift_en) begin
         line_q.push_front(din);
         void'(line_q.pop_back());
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1 actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input logic [L-1:0] act, input logic [L-1:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(tap1,  line_q[sel1],        "R1/R7 first tap vs model");
      chk(casc1, line_q[D-1],         "R5 first cascade vs model");
      chk(tap2,  line_q[D + sel2],    "R8/R9 chained flat tap vs model");
      chk(casc2, line_q[2*D-1],       "R8 chained cascade vs model");
   endtask

   logic [L-1:0] snap[D];

   initial begin
      shift_en = 1'b0;
      din      = '0;
      sel1     = '0;
      sel2     = '0;

      // R6: power-up contents equal INIT_BIT; R4: taps follow the address with no edge
      #1;
      for (int s = 0; s < D; s++) begin
         sel1 = AW'(s);
         sel2 = AW'(D-1-s);
         #1;
         chk(tap1, {L{INIT}}, "R6 power-up tap first unit");
         chk(tap2, {L{INIT}}, "R6 power-up tap second unit");
      end
      chk(casc1, {L{INIT}}, "R6 power-up cascade");

      // Flush with zeros (64 enabled edges)
      for (int c = 0; c < 2*D; c++) begin
         @(negedge clk);
         shift_en = 1'b1;
         din      = '0;
      end

      // R3: impulse on lane 0 only; after edge m it sits at stage m-1
      @(negedge clk);
      din = 4'b0001;
      @(negedge clk);
      din = '0;
      for (int m = 1; m <= D; m++) begin
         sel1 = AW'(m - 1);
         #1;
         chk(tap1, 4'b0001, "R3 impulse at tap N after N+1 edges");
         if (m < D) begin
            sel1 = AW'(m);
            #1;
            chk(tap1, 4'b0000, "R3 impulse absent from tap N+1");
         end
         if (m == D) chk(casc1, 4'b0001, "R5 impulse on cascade at last stage");
         @(negedge clk);
      end
      // One edge later the impulse leaves the first unit into the second (R8)
      sel2 = '0;
      #1;
      chk(tap2, 4'b0001, "R8 impulse crosses into second unit");
      chk(casc1, 4'b0000, "R5 cascade after impulse left");

      // Load a varied pattern, then R2: disabled edges keep all stages
      for (int c = 0; c < D; c++) begin
         @(negedge clk);
         shift_en = 1'b1;
         din      = L'(c * 7 + 3);
      end
      @(negedge clk);
      shift_en = 1'b0;
      for (int s = 0; s < D; s++) begin
         sel1 = AW'(s);
         #1;
         snap[s] = tap1;
      end
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         din = ~din;
      end
      for (int s = 0; s < D; s++) begin
         sel1 = AW'(s);
         #1;
         chk(tap1, snap[s], "R2 stage unchanged with enable low");
      end

      // Random run against the queue model (R1 R3 R4 R5 R7 R8 R9)
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         shift_en = ($urandom_range(0, 3) != 0);
         din      = L'($urandom);
         sel1     = AW'($urandom);
         sel2     = AW'($urandom);
         #1;
         compare_all();
         sel1 = AW'($urandom);
         #1;
         chk(tap1, line_q[sel1], "R4 address change seen without edge");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule